// File: doc/BRIEF.md
# Controllable Adder-Subtractor with Borrow Input

This block is a purely combinational adder-subtractor with an 8-bit default width. A single mode input selects between two operations. In add mode it forms the sum of the two operands plus an incoming carry. In subtract mode it forms the first operand minus the second. In that mode the same carry input is read as an active-high borrow.

Internally the second operand passes through a row of XOR gates driven by the mode bit. The carry into the least significant full adder is the mode bit XOR the external carry input. A chain of single-bit full adders then ripples the carry from bit 0 to the top bit. The raw carry out of the top bit is brought out, together with a two's-complement overflow flag.

Several instances can be chained to work on wider words, lowest word first. In add mode the carry-out of one word feeds the carry input of the next. In subtract mode the next word's borrow input is the inverse of the lower word's carry-out.

Top module: `addsub_borrow_unit`

## Requirements
- R1: With sub_i = 0, {cout_o, s_o} equals x_i + y_i + cin_i taken as an unsigned 9-bit sum, so cin_i acts as an ordinary carry-in.
- R2: With sub_i = 1 and cin_i = 0, s_o equals (x_i - y_i) mod 256.
- R3: With sub_i = 1 and cin_i = 1, cin_i acts as a borrow and s_o equals (x_i - y_i - 1) mod 256.
- R4: In subtract mode, cout_o is 1 when x_i >= y_i + cin_i as unsigned numbers, and 0 when a borrow out of the word occurs.
- R5: ovf_o is 1 exactly when the two's-complement result falls outside -128..127. In add mode that result is x_i + y_i + cin_i, and in subtract mode it is x_i - y_i - cin_i, with x_i and y_i read as signed 8-bit values. This is the same as the XOR of the carries into and out of bit 7.
- R6: Two instances can be chained into one 16-bit operation. For an add, the upper cin_i takes the lower cout_o. For a subtract, the upper cin_i takes the inverse of the lower cout_o. The chained results equal the 16-bit sum or difference with carry or borrow.
- R7: The outputs depend only on the present inputs and hold no state. Any new input pattern gives its own result, whatever the inputs were before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 8 | First operand (minuend in subtract mode) |
| y_i | input | 8 | Second operand (subtrahend in subtract mode) |
| sub_i | input | 1 | Mode: 0 add, 1 subtract |
| cin_i | input | 1 | Carry-in in add mode, borrow-in in subtract mode |
| s_o | output | 8 | Sum or difference |
| cout_o | output | 1 | Raw carry out of the top bit (0 means borrow in subtract mode) |
| ovf_o | output | 1 | Two's-complement overflow |

## Verification
The bound checker compares the ripple chain's outputs against plain arithmetic whenever the inputs change. Its checks cover the sum in add mode, the difference in both borrow cases, the meaning of the carry-out as a borrow, and the overflow flag against a signed range test. Two behaviours need the bench's scenarios instead. One is multi-word chaining, which passes the carry or inverted carry from one word into the next. The other is the absence of state, shown by following extreme patterns with unrelated ones.

// File: rtl/addsub_pkg.sv
// Package: shared types for the adder-subtractor.
// Assumes nothing beyond a 1-bit mode encoding.
package addsub_pkg;
    typedef enum logic {
        MODE_ADD = 1'b0,
        MODE_SUB = 1'b1
    } addsub_mode_e;
endpackage

// File: rtl/addsub_operand_cond.sv
// Operand conditioning: inverts the second operand in subtract mode and
// forms the carry into bit 0 as mode XOR the external carry/borrow input.
// Assumes: mode encoding from addsub_pkg.
module addsub_operand_cond
    import addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] y_i,
    input  addsub_mode_e     mode_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] y_cond_o,
    output logic             c0_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    // Conditional one's complement of the second operand and bit-0 carry.
    always_comb begin
        y_cond_o = (mode_i == MODE_SUB) ? (y_i ^ ALL_ONES) : y_i;
        c0_o     = (mode_i == MODE_SUB) ^ cin_i;
    end
endmodule

// File: rtl/addsub_full_adder.sv
// Single-bit full adder.
// Assumes: used as one stage of a ripple chain.
module addsub_full_adder (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    // Sum and majority carry of three input bits.
    always_comb begin
        s_o = a_i ^ b_i ^ c_i;
        c_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
    end
endmodule

// File: rtl/addsub_ripple_chain.sv
// Ripple-carry chain of WIDTH full adders, bit 0 first.
// Exposes the carry into and out of the top bit for overflow detection.
// Assumes: WIDTH >= 2.
module addsub_ripple_chain #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             c0_i,
    output logic [WIDTH-1:0] s_o,
    output logic             c_msb_in_o,
    output logic             c_msb_out_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] carry;

    // Seed the chain with the conditioned carry-in.
    always_comb carry[0] = c0_i;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_stage
        addsub_full_adder fa_i (
            .a_i (a_i[gi]),
            .b_i (b_i[gi]),
            .c_i (carry[gi]),
            .s_o (s_o[gi]),
            .c_o (carry[gi+1])
        );
    end

    // Tap the carries around the top bit.
    always_comb begin
        c_msb_in_o  = carry[MSB];
        c_msb_out_o = carry[WIDTH];
    end
endmodule

// File: rtl/addsub_overflow.sv
// Signed overflow detection from the carries around the top bit.
// Assumes: carries come from a two's-complement ripple chain.
module addsub_overflow (
    input  logic c_msb_in_i,
    input  logic c_msb_out_i,
    output logic ovf_o
);
    // Overflow when the carry into the sign bit differs from the carry out.
    always_comb ovf_o = c_msb_in_i ^ c_msb_out_i;
endmodule

// File: rtl/addsub_borrow_unit.sv
// Top: controllable adder-subtractor. sub_i = 0 adds with carry-in,
// sub_i = 1 subtracts with cin_i read as a borrow. Purely combinational.
// Assumes: operands are unsigned or two's complement of WIDTH bits.
module addsub_borrow_unit
    import addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             sub_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] s_o,
    output logic             cout_o,
    output logic             ovf_o
);
    addsub_mode_e     mode;
    logic [WIDTH-1:0] y_cond;
    logic             c0;
    logic             c_msb_in;
    logic             c_msb_out;

    // Map the raw mode pin onto the shared mode type.
    always_comb mode = sub_i ? MODE_SUB : MODE_ADD;

    addsub_operand_cond #(.WIDTH(WIDTH)) cond_i (
        .y_i      (y_i),
        .mode_i   (mode),
        .cin_i    (cin_i),
        .y_cond_o (y_cond),
        .c0_o     (c0)
    );

    addsub_ripple_chain #(.WIDTH(WIDTH)) chain_i (
        .a_i         (x_i),
        .b_i         (y_cond),
        .c0_i        (c0),
        .s_o         (s_o),
        .c_msb_in_o  (c_msb_in),
        .c_msb_out_o (c_msb_out)
    );

    addsub_overflow ovf_i (
        .c_msb_in_i  (c_msb_in),
        .c_msb_out_i (c_msb_out),
        .ovf_o       (ovf_o)
    );

    // Carry-out is the raw carry from the top stage.
    always_comb cout_o = c_msb_out;
endmodule

// File: rtl/addsub_borrow_unit_chk.sv
// Checker: compares the ripple chain against plain arithmetic on every
// input change. Bound to addsub_borrow_unit below.
module addsub_borrow_unit_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] x_i,
    input logic [WIDTH-1:0] y_i,
    input logic             sub_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] s_o,
    input logic             cout_o,
    input logic             ovf_o
);
    localparam int SMAX = (1 << (WIDTH - 1)) - 1;
    localparam int SMIN = -(1 << (WIDTH - 1));

    logic [WIDTH:0]   add_ref;
    logic [WIDTH-1:0] diff_ref;
    logic [WIDTH:0]   y_plus_b;
    int               sx;
    int               sy;
    int               sres;
    logic             ovf_ref;

    // Reference arithmetic and assertions.
    always_comb begin
        add_ref  = {1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i};
        diff_ref = x_i - y_i - {{(WIDTH-1){1'b0}}, cin_i};
        y_plus_b = {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i};
        sx       = int'($signed(x_i));
        sy       = int'($signed(y_i));
        sres     = sub_i ? (sx - sy - int'(cin_i)) : (sx + sy + int'(cin_i));
        ovf_ref  = (sres > SMAX) || (sres < SMIN);

        // R1
        add_sum_chk: assert (sub_i || ({cout_o, s_o} == add_ref));
        // R2
        sub_noborrow_chk: assert (!(sub_i && !cin_i) || (s_o == diff_ref));
        // R3
        sub_borrow_chk: assert (!(sub_i && cin_i) || (s_o == diff_ref));
        // R4
        borrow_out_chk: assert (!sub_i || (cout_o == ({1'b0, x_i} >= y_plus_b)));
        // R5
        overflow_chk: assert (ovf_o == ovf_ref);
    end
endmodule

bind addsub_borrow_unit addsub_borrow_unit_chk #(.WIDTH(WIDTH)) chk_i (
    .x_i    (x_i),
    .y_i    (y_i),
    .sub_i  (sub_i),
    .cin_i  (cin_i),
    .s_o    (s_o),
    .cout_o (cout_o),
    .ovf_o  (ovf_o)
);

// File: tb/addsub_borrow_unit_tb_top.sv
// Scoreboard bench: the driver applies inputs on the rising edge and
// queues expected results; the monitor compares on the falling edge.
module addsub_borrow_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    typedef struct {
        logic [7:0] s;
        logic       cout;
        logic       ovf;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] x = '0;
    logic [7:0] y = '0;
    logic       sub = 1'b0;
    logic       cin = 1'b0;
    logic [7:0] s;
    logic       cout;
    logic       ovf;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;
    exp_t       sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    addsub_borrow_unit dut_i (
        .x_i(x), .y_i(y), .sub_i(sub), .cin_i(cin),
        .s_o(s), .cout_o(cout), .ovf_o(ovf)
    );

    function automatic exp_t model(input logic [7:0] a, input logic [7:0] b,
                                   input logic m, input logic c, input string r);
        exp_t e;
        int   u;
        int   sr;
        if (!m) u = int'(a) + int'(b) + int'(c);
        else    u = int'(a) - int'(b) - int'(c);
        e.s    = u[7:0];
        e.cout = m ? (u >= 0) : (u > 255);
        if (!m) sr = int'($signed(a)) + int'($signed(b)) + int'(c);
        else    sr = int'($signed(a)) - int'($signed(b)) - int'(c);
        e.ovf  = (sr > 127) || (sr < -128);
        e.req  = r;
        return e;
    endfunction

    task automatic check(input string r, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    // Driver: apply one pattern and queue its expected result.
    task automatic drive(input logic [7:0] a, input logic [7:0] b,
                         input logic m, input logic c, input string r);
        @(posedge clk);
        x = a; y = b; sub = m; cin = c;
        sb_q.push_back(model(a, b, m, c, r));
    endtask

    // Monitor: compare outputs against the queue head away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.req, "sum", int'(s), int'(e.s));
                check(e.req, "cout", int'(cout), int'(e.cout));
                check(e.req, "ovf", int'(ovf), int'(e.ovf));
            end
        end
    end

    // Chain two words through the single instance: R6.
    task automatic chain16(input logic [15:0] a, input logic [15:0] b, input logic m);
        logic [7:0] lo;
        logic       lc;
        int         full;
        @(posedge clk);
        x = a[7:0]; y = b[7:0]; sub = m; cin = 1'b0;
        @(negedge clk);
        lo = s; lc = cout;
        @(posedge clk);
        x = a[15:8]; y = b[15:8]; cin = m ? ~lc : lc;
        @(negedge clk);
        full = m ? (int'(a) - int'(b)) : (int'(a) + int'(b));
        check("R6", "chained word", int'({s, lo}), int'(full[15:0]));
        check("R6", "chained carry", int'(cout), m ? int'(full >= 0) : int'(full > 65535));
    endtask

    initial begin
        // Reset state: all-zero inputs give a zero result (R1).
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset sum", int'(s), 0);
        check("R1", "reset cout", int'(cout), 0);
        check("R5", "reset ovf", int'(ovf), 0);

        // Directed corners.
        drive(8'hFF, 8'h01, 1'b0, 1'b0, "R1");
        drive(8'hFF, 8'h00, 1'b0, 1'b1, "R1");
        drive(8'h7F, 8'h01, 1'b0, 1'b0, "R5");
        drive(8'h80, 8'h80, 1'b0, 1'b0, "R5");
        drive(8'h7F, 8'h00, 1'b0, 1'b1, "R5");
        drive(8'h05, 8'h05, 1'b1, 1'b0, "R2");
        drive(8'h00, 8'h01, 1'b1, 1'b0, "R4");
        drive(8'h05, 8'h05, 1'b1, 1'b1, "R3");
        drive(8'h06, 8'h05, 1'b1, 1'b1, "R4");
        drive(8'h80, 8'h01, 1'b1, 1'b0, "R5");
        drive(8'h7F, 8'hFF, 1'b1, 1'b0, "R5");
        drive(8'h80, 8'h00, 1'b1, 1'b1, "R5");
        drive(8'h00, 8'h00, 1'b1, 1'b1, "R3");
        // No state: extreme then unrelated pattern (R7).
        drive(8'hFF, 8'hFF, 1'b0, 1'b1, "R7");
        drive(8'h12, 8'h34, 1'b0, 1'b0, "R7");

        // Sweep: every x against a spread of y in all four modes.
        for (int xi = 0; xi < 256; xi++) begin
            for (int yi = 0; yi < 256; yi += 17) begin
                drive(8'(xi), 8'(yi), 1'b0, 1'b0, "R1");
                drive(8'(xi), 8'(yi), 1'b0, 1'b1, "R1");
                drive(8'(xi), 8'(yi), 1'b1, 1'b0, "R2");
                drive(8'(xi), 8'(yi), 1'b1, 1'b1, "R3");
            end
        end
        repeat (2) @(posedge clk);

        // Multi-word chaining.
        chain16(16'h00FF, 16'h0001, 1'b0);
        chain16(16'hFFFF, 16'h0001, 1'b0);
        chain16(16'h0100, 16'h0001, 1'b1);
        chain16(16'h1234, 16'h1235, 1'b1);
        chain16(16'hABCD, 16'h1234, 1'b1);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        done = 1'b1;
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule